// File: doc/BRIEF.md
# Tributary Overhead Persistence Detector

This block watches the per-frame overhead of one second-order stream that carries four tributaries. A framer upstream extracts the bits and presents them in parallel with a one-cycle frame strobe. For each tributary the block takes the three stuffing-control bits of its subframe. When the third bit disagrees with both of the other two, the far end is asking for a loopback on that tributary. A separate remote-alarm bit and a reserved bit are also received once per frame.

Each indication goes through a persistence filter before it reaches an output. A loopback flag changes state only after five frames in a row that call for the change. The alarm flag and the reported reserved bit each need four frames in a row. A run that breaks early starts its count again from zero. Frames that arrive while the stream is out of frame are skipped, and any count in progress is kept. The active level of the alarm bit depends on the format: it is low in the DS2-style format and high in the E1-style format. The four loopback flags belong to global positions x = 4(y-1)+z, where y is the stream number set by a parameter and z is the tributary within the stream.

Top module: `trib_oh_persist`

## Requirements
- R1: The loopback flag `lb_det[z-1]` goes to 1 after 5 consecutive accepted frames in which tributary z's control group, taken as {third, second, first} in `cbits[3z-1:3z-3]`, reads 3'b100 or 3'b011. Any other code, such as 3'b010, does not count towards setting the flag.
- R2: A set loopback flag returns to 0 after 5 consecutive accepted frames in which that group reads any code other than 3'b100 or 3'b011.
- R3: When a run of frames calling for a change is broken before it reaches the required length (5 for loopback, 4 for alarm and reserved), the run count goes back to zero and the output stays as it was.
- R4: `lb_first_index` equals 4*(STREAM_NUM-1)+1, so tributary z, reported on `lb_det[z-1]`, has global index `lb_first_index`+z-1.
- R5: With `fmt_e1`=0, `rai_det` goes to 1 after `alm_bit`=0 in 4 consecutive accepted frames, and returns to 0 only after `alm_bit`=1 in 4 consecutive accepted frames.
- R6: With `fmt_e1`=1 the alarm polarity is inverted: `rai_det` goes to 1 after `alm_bit`=1 in 4 consecutive accepted frames, and returns to 0 after `alm_bit`=0 in 4 consecutive accepted frames.
- R7: `rsv_rpt` takes a new value of `rsv_bit` only after that value has been received in 4 consecutive accepted frames.
- R8: A frame is accepted only when `frm_vld`=1 and `oof`=0. Any other cycle leaves every output and every run count unchanged.
- R9: While `rst_n`=0 and after it is released, `lb_det`=0, `rai_det`=0 and `rsv_rpt`=1. Outputs update on the clock edge that samples the deciding frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_vld | input | 1 | One-cycle strobe marking valid overhead for one frame |
| oof | input | 1 | Stream out of frame; frames with this bit high are skipped |
| fmt_e1 | input | 1 | 0 = DS2-style format (alarm active low), 1 = E1-style format (alarm active high) |
| cbits | input | 12 | Control groups of the four tributaries, 3 bits each, tributary 1 in the low bits |
| alm_bit | input | 1 | Received remote-alarm bit |
| rsv_bit | input | 1 | Received reserved bit |
| lb_det | output | 4 | Filtered loopback request, one bit per tributary |
| rai_det | output | 1 | Filtered remote alarm indication |
| rsv_rpt | output | 1 | Filtered reserved-bit value |
| lb_first_index | output | 6 | Global loopback index of tributary 1 of this stream |

## Verification
The bench sets flags with the fifth matching frame and clears them with the fifth non-matching frame. A design with an off-by-one run length would move the flag one frame early or late. It places an out-of-frame frame in the middle of runs and breaks runs at the fourth frame. A design that counted skipped frames, or did not restart a broken run, would move a flag where the table expects it to stay. It switches format while the alarm flag is set to check the polarity swap, and it applies the partial-disagreement code 3'b010 to catch a decoder that only compares the third bit with one of the other two.

// File: rtl/trib_oh_pkg.sv
package trib_oh_pkg;

  typedef logic [2:0] cgrp_t;

  // Loopback request: third bit differs from both the first and the second.
  function automatic logic lb_pattern(input cgrp_t g);
    return (g[2] != g[0]) && (g[2] != g[1]);
  endfunction

  // Alarm bit mapped to "alarm asserted" level for the selected format.
  function automatic logic rai_active(input logic fmt_e1, input logic bit_in);
    return fmt_e1 ? bit_in : ~bit_in;
  endfunction

  // Global loopback index of tributary z (1-based) in stream y (1-based).
  function automatic int unsigned lb_global_index(input int unsigned y,
                                                  input int unsigned z);
    return 4 * y - 4 + z;
  endfunction

endpackage

// File: rtl/persist_filter.sv
module persist_filter #(
  parameter int unsigned COUNT   = 5,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic sample,
  output logic q,
  output logic flip_evt
);
  localparam int unsigned CW = (COUNT > 1) ? $clog2(COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

  logic [CW-1:0] run_cnt;
  logic          differ;

  assign differ   = (sample != q);
  assign flip_evt = adv && differ && (run_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q       <= RST_VAL;
      run_cnt <= '0;
    end else if (adv) begin
      if (!differ) begin
        run_cnt <= '0;
      end else if (run_cnt == LAST) begin
        q       <= ~q;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  // R8
  q_moves_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |-> $past(adv));

  // R3
  run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !differ) |=> (run_cnt == '0));

  // R1
  flip_applied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flip_evt |=> (q != $past(q)));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(run_cnt));

endmodule

// File: rtl/lb_bank.sv
module lb_bank
  import trib_oh_pkg::*;
#(
  parameter int unsigned NUM_TRIB = 4,
  parameter int unsigned LB_RUN   = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv,
  input  logic [NUM_TRIB*3-1:0] cbits,
  output logic [NUM_TRIB-1:0]   lb_det,
  output logic [NUM_TRIB-1:0]   lb_evt
);
  logic [NUM_TRIB-1:0] req;

  for (genvar i = 0; i < NUM_TRIB; i++) begin : g_trib
    assign req[i] = lb_pattern(cbits[3*i +: 3]);

    persist_filter #(
      .COUNT   (LB_RUN),
      .RST_VAL (1'b0)
    ) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .sample   (req[i]),
      .q        (lb_det[i]),
      .flip_evt (lb_evt[i])
    );
  end

  // R1
  lb_set_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lb_det[0])) |-> $past(req[0]));

  // R2
  lb_clr_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lb_det[0])) |-> !$past(req[0]));

endmodule

// File: rtl/status_filters.sv
module status_filters
  import trib_oh_pkg::*;
#(
  parameter int unsigned ALM_RUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic fmt_e1,
  input  logic alm_bit,
  input  logic rsv_bit,
  output logic rai_det,
  output logic rsv_rpt,
  output logic rai_evt,
  output logic rsv_evt
);
  logic alm_level;

  assign alm_level = rai_active(fmt_e1, alm_bit);

  persist_filter #(
    .COUNT   (ALM_RUN),
    .RST_VAL (1'b0)
  ) u_rai (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .sample   (alm_level),
    .q        (rai_det),
    .flip_evt (rai_evt)
  );

  persist_filter #(
    .COUNT   (ALM_RUN),
    .RST_VAL (1'b1)
  ) u_rsv (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .sample   (rsv_bit),
    .q        (rsv_rpt),
    .flip_evt (rsv_evt)
  );

  // R7
  rsv_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsv_rpt) |-> (rsv_rpt == $past(rsv_bit)));

  // R5
  rai_ds2_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rai_det) && !$past(fmt_e1)) |-> !$past(alm_bit));

  // R6
  rai_e1_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rai_det) && $past(fmt_e1)) |-> $past(alm_bit));

endmodule

// File: rtl/trib_oh_persist.sv
module trib_oh_persist
  import trib_oh_pkg::*;
#(
  parameter int unsigned NUM_TRIB   = 4,
  parameter int unsigned LB_RUN     = 5,
  parameter int unsigned ALM_RUN    = 4,
  parameter int unsigned STREAM_NUM = 1,
  parameter int unsigned IDX_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frm_vld,
  input  logic                  oof,
  input  logic                  fmt_e1,
  input  logic [NUM_TRIB*3-1:0] cbits,
  input  logic                  alm_bit,
  input  logic                  rsv_bit,
  output logic [NUM_TRIB-1:0]   lb_det,
  output logic                  rai_det,
  output logic                  rsv_rpt,
  output logic [IDX_W-1:0]      lb_first_index
);
  localparam int unsigned FIRST_IDX = lb_global_index(STREAM_NUM, 1);

  logic                adv;
  logic [NUM_TRIB-1:0] lb_evt;
  logic                rai_evt;
  logic                rsv_evt;

  assign adv            = frm_vld && !oof;
  assign lb_first_index = IDX_W'(FIRST_IDX);

  lb_bank #(
    .NUM_TRIB (NUM_TRIB),
    .LB_RUN   (LB_RUN)
  ) u_lb (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (adv),
    .cbits  (cbits),
    .lb_det (lb_det),
    .lb_evt (lb_evt)
  );

  status_filters #(
    .ALM_RUN (ALM_RUN)
  ) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .fmt_e1  (fmt_e1),
    .alm_bit (alm_bit),
    .rsv_bit (rsv_bit),
    .rai_det (rai_det),
    .rsv_rpt (rsv_rpt),
    .rai_evt (rai_evt),
    .rsv_evt (rsv_evt)
  );

  // R8
  oof_frame_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && oof) |=> ($stable(lb_det) && $stable(rai_det) && $stable(rsv_rpt)));

  // R8
  events_need_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|lb_evt || rai_evt || rsv_evt) |-> (frm_vld && !oof));

  // R9
  reset_values_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (lb_det == '0 && !rai_det && rsv_rpt));

endmodule

// File: tb/tb_trib_oh_persist.sv
module tb_trib_oh_persist;
  localparam int unsigned STREAM = 2;
  localparam int unsigned NV     = 21;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frm_vld, oof, fmt_e1, alm_bit, rsv_bit;
  logic [11:0] cbits;
  logic [3:0]  lb_det;
  logic        rai_det, rsv_rpt;
  logic [5:0]  lb_first_index;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trib_oh_persist #(.STREAM_NUM(STREAM)) dut (
    .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .oof(oof), .fmt_e1(fmt_e1),
    .cbits(cbits), .alm_bit(alm_bit), .rsv_bit(rsv_bit), .lb_det(lb_det),
    .rai_det(rai_det), .rsv_rpt(rsv_rpt), .lb_first_index(lb_first_index)
  );

  // {oof, fmt_e1, cbits[11:0], alm, rsv, exp_lb[3:0], exp_rai, exp_rsv}
  localparam logic [21:0] VEC [NV] = '{
    {1'b0,1'b0,12'b000000011100,1'b1,1'b1,4'b0000,1'b0,1'b1},
    {1'b0,1'b0,12'b000000011100,1'b1,1'b1,4'b0000,1'b0,1'b1},
    {1'b0,1'b0,12'b000000011100,1'b1,1'b1,4'b0000,1'b0,1'b1},
    {1'b0,1'b0,12'b000000011100,1'b1,1'b1,4'b0000,1'b0,1'b1},
    {1'b0,1'b0,12'b000000000100,1'b1,1'b1,4'b0001,1'b0,1'b1},
    {1'b1,1'b0,12'b000000011000,1'b0,1'b0,4'b0001,1'b0,1'b1},
    {1'b0,1'b0,12'b000000011000,1'b0,1'b0,4'b0001,1'b0,1'b1},
    {1'b0,1'b0,12'b000000011000,1'b0,1'b0,4'b0001,1'b0,1'b1},
    {1'b0,1'b0,12'b000000011000,1'b0,1'b0,4'b0001,1'b0,1'b1},
    {1'b0,1'b0,12'b000000011000,1'b0,1'b0,4'b0001,1'b1,1'b0},
    {1'b0,1'b0,12'b000000011000,1'b0,1'b0,4'b0010,1'b1,1'b0},
    {1'b0,1'b1,12'b000000011000,1'b0,1'b1,4'b0010,1'b1,1'b0},
    {1'b0,1'b1,12'b000000011000,1'b0,1'b0,4'b0010,1'b1,1'b0},
    {1'b0,1'b1,12'b000000011000,1'b0,1'b0,4'b0010,1'b1,1'b0},
    {1'b0,1'b1,12'b000000011000,1'b0,1'b0,4'b0010,1'b0,1'b0},
    {1'b0,1'b1,12'b000100011000,1'b1,1'b0,4'b0010,1'b0,1'b0},
    {1'b0,1'b1,12'b000100011000,1'b0,1'b0,4'b0010,1'b0,1'b0},
    {1'b0,1'b1,12'b000100011000,1'b1,1'b0,4'b0010,1'b0,1'b0},
    {1'b0,1'b1,12'b000100011000,1'b1,1'b0,4'b0010,1'b0,1'b0},
    {1'b0,1'b1,12'b000100011000,1'b1,1'b0,4'b0110,1'b0,1'b0},
    {1'b0,1'b1,12'b000100011000,1'b1,1'b0,4'b0110,1'b1,1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic frame(input logic vld, input logic o, input logic f,
                       input logic [11:0] c, input logic a, input logic r);
    @(negedge clk);
    frm_vld = vld; oof = o; fmt_e1 = f; cbits = c; alm_bit = a; rsv_bit = r;
    @(posedge clk);
    #1;
    frm_vld = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frm_vld = 1'b0; oof = 1'b0; fmt_e1 = 1'b0;
    cbits = '0; alm_bit = 1'b1; rsv_bit = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check("R9 lb", {4'b0, lb_det}, 8'h00);
    check("R9 rai", {7'b0, rai_det}, 8'h00);
    check("R9 rsv", {7'b0, rsv_rpt}, 8'h01);
    @(negedge clk);
    rst_n = 1'b1;
    // R4 global index of tributary 1 for stream 2
    check("R4 index", {2'b0, lb_first_index}, 8'(4 * STREAM - 4 + 1));

    // Table: R1 R2 R3 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      frame(1'b1, v[21], v[20], v[19:8], v[7], v[6]);
      check("R1/R2/R3 lb", {4'b0, lb_det}, {4'b0, v[5:2]});
      check("R5/R6 rai", {7'b0, rai_det}, {7'b0, v[1]});
      check("R7/R8 rsv", {7'b0, rsv_rpt}, {7'b0, v[0]});
    end

    // R8: strobe low frames have no effect on a pending pattern
    for (int i = 0; i < 6; i++)
      frame(1'b0, 1'b0, 1'b1, 12'b100000011100, 1'b0, 1'b1);
    check("R8 idle lb", {4'b0, lb_det}, 8'h06);
    check("R8 idle rai", {7'b0, rai_det}, 8'h01);
    check("R8 idle rsv", {7'b0, rsv_rpt}, 8'h00);

    // R1: partial disagreement 3'b010 on tributary 4 never sets
    for (int i = 0; i < 6; i++)
      frame(1'b1, 1'b0, 1'b1, 12'b010100011000, 1'b1, 1'b0);
    check("R1 partial code", {4'b0, lb_det}, 8'h06);

    // R1: tributary 4 with code 3'b011 sets on the fifth frame exactly
    for (int i = 0; i < 4; i++)
      frame(1'b1, 1'b0, 1'b1, 12'b011100011000, 1'b1, 1'b0);
    check("R1 four frames", {4'b0, lb_det}, 8'h06);
    frame(1'b1, 1'b0, 1'b1, 12'b011100011000, 1'b1, 1'b0);
    check("R1 fifth frame", {4'b0, lb_det}, 8'h0E);

    // R9: reset mid-run returns all outputs to reset values
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check("R9 rerst lb", {4'b0, lb_det}, 8'h00);
    check("R9 rerst rai", {7'b0, rai_det}, 8'h00);
    check("R9 rerst rsv", {7'b0, rsv_rpt}, 8'h01);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule